// File: doc/BRIEF.md
# Tick-Sampled PS/2 Keyboard Receiver

This block receives frames from a PS/2 device without ever using the PS/2 clock as a clock. The device's clock and data lines are first brought into the system clock domain. Their levels are then read only when `sample_tick` is high. `sample_tick` is a periodic strobe that must run at more than twice the highest PS/2 clock rate, which is 16.7 kHz.

The per-window state is small. A 2-bit phase counts clock-line transitions modulo four. A 2-bit data field acts as a tiny shift register that captures the data line on every high-to-low clock transition. A process window is closed by `win_end`. At that point the block works out how many bits arrived during the window (zero, one or two) by comparing the phase with its value at the end of the previous window. It then moves those bits, oldest first, into an 11-bit frame register.

A full frame has a start bit, eight data bits sent least significant bit first, an odd parity bit and a stop bit. A good frame yields the byte and a one-cycle valid strobe. A bad frame yields a one-cycle error strobe. A quiet clock line for too many ticks abandons a partial frame.

Top module: `ps2s_rx`

## Requirements
- R1: While `rst_n` is low and after it is released, `code` is 0, `code_valid`, `err_parity` and `err_frame` are 0, and no partial frame is held.
- R2: The PS/2 lines pass through `SYNC_STAGES` flip-flops and are examined only on cycles with `sample_tick` high; a short pulse that has cleared the synchronizer output before the next tick has no effect on any received frame.
- R3: The phase is a 2-bit transition count modulo four, where even values mean the clock was last seen high and odd values mean low. At each `win_end`, the number of bits delivered depends on the phase at the previous window close and on the forward difference d between the two phase values. If that earlier phase was even, d = 0, 1, 2, 3 delivers 0, 1, 1, 2 bits. If it was odd, d = 0, 1, 2, 3 delivers 0, 0, 1, 1 bits. A window must contain at most three transitions.
- R4: A data bit is captured only on a tick where the sampled clock goes from high to low, and it takes the data level sampled on that same tick; rising edges and ticks with no transition capture nothing.
- R5: A frame is 11 captured bits in arrival order: start (must be 0), data bit 0 through data bit 7, parity, stop (must be 1). When all checks pass, `code` takes the 8 data bits and `code_valid` is high for exactly one cycle; `code` holds its value until the next good frame.
- R6: If the eight data bits plus the parity bit contain an even number of ones, `err_parity` pulses for one cycle and `code` is not updated.
- R7: If the start bit is 1 or the stop bit is 0, `err_frame` pulses for one cycle and `code` is not updated.
- R8: If `TIMEOUT_TICKS` consecutive ticks pass with no falling clock edge, the partial frame and any undelivered bits of the current window are discarded, so the next falling edge begins a new frame.
- R9: After every completed frame, good or bad, the bit count restarts at zero, so back-to-back frames are each decoded on their own.
- R10: `code_valid` never coincides with an error strobe, and no strobe lasts more than one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_tick | input | 1 | Periodic sampling strobe for the PS/2 lines |
| win_end | input | 1 | Closes a process window; asserted only together with `sample_tick` |
| ps2_clk | input | 1 | PS/2 clock line level (asynchronous) |
| ps2_dat | input | 1 | PS/2 data line level (asynchronous) |
| code | output | 8 | Last correctly received byte |
| code_valid | output | 1 | One-cycle strobe: a good frame was received |
| err_parity | output | 1 | One-cycle strobe: parity check failed |
| err_frame | output | 1 | One-cycle strobe: bad start or stop bit |

## Verification
The bench builds the receiver with `TIMEOUT_TICKS` = 20 and the default two-stage synchronizer, and issues a tick every fourth clock. With those values, a five-bit partial frame followed by thirty quiet ticks triggers the timeout in a few hundred cycles. Frames are sent with PS/2 half-periods of one, two and three ticks against windows of three, five and seven ticks. This makes windows that deliver zero, one and two bits and that close on every phase parity. A one-clock glitch placed between ticks probes the sampling rule.

// File: rtl/ps2s_pkg.sv
package ps2s_pkg;

    localparam int FRAME_BITS = 11;
    localparam int CNT_W      = $clog2(FRAME_BITS);

    typedef struct packed {
        logic [1:0] phase;   // transitions mod 4; even = clock high
        logic [1:0] bits;    // last two captured data bits, newest in [0]
        logic [1:0] snap;    // phase at last window close
    } edge_st_t;

    typedef struct packed {
        logic [FRAME_BITS-1:0] sh;
        logic [CNT_W-1:0]      cnt;
        logic [7:0]            code;
        logic                  vld;
        logic                  perr;
        logic                  ferr;
    } frame_st_t;

endpackage

// File: rtl/ps2s_sync.sv
module ps2s_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] ff_q;
    logic [STAGES-1:0] ff_d;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                assign ff_d[s] = d;
            end else begin : g_next
                assign ff_d[s] = ff_q[s-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) ff_q <= '1;
        else        ff_q <= ff_d;
    end

    assign q = ff_q[STAGES-1];
endmodule

// File: rtl/ps2s_edge.sv
module ps2s_edge
    import ps2s_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       win_end,
    input  logic       flush,
    input  logic       clk_lvl,
    input  logic       dat_lvl,
    output logic       fall,
    output logic [1:0] nbits,
    output logic [1:0] win_bits
);
    edge_st_t st_d, st_q;
    logic       rise;
    logic [1:0] delta;

    always_comb begin
        st_d  = st_q;
        fall  = tick && !clk_lvl && !st_q.phase[0];
        rise  = tick &&  clk_lvl &&  st_q.phase[0];
        if (fall || rise) st_d.phase = st_q.phase + 2'd1;
        if (fall)         st_d.bits  = {st_q.bits[0], dat_lvl};
        delta = st_d.phase - st_q.snap;
        unique case ({st_q.snap[0], delta})
            3'b000: nbits = 2'd0;
            3'b001: nbits = 2'd1;
            3'b010: nbits = 2'd1;
            3'b011: nbits = 2'd2;
            3'b100: nbits = 2'd0;
            3'b101: nbits = 2'd0;
            3'b110: nbits = 2'd1;
            default: nbits = 2'd1;
        endcase
        win_bits = st_d.bits;
        if (win_end || flush) st_d.snap = st_d.phase;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: phase moves only on sampling ticks
    p_phase_tick_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(st_q.phase));

    // R3: at most one transition is recorded per tick
    p_phase_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (st_q.phase == $past(st_q.phase)) ||
                 (st_q.phase == $past(st_q.phase) + 2'd1));

    // R4: data field shifts only on a detected falling edge
    p_capture_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !fall |=> $stable(st_q.bits));
endmodule

// File: rtl/ps2s_frame.sv
module ps2s_frame
    import ps2s_pkg::*;
#(
    parameter int TIMEOUT_TICKS = 80
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       win_end,
    input  logic       fall,
    input  logic [1:0] nbits,
    input  logic [1:0] win_bits,
    output logic       flush,
    output logic [7:0] code,
    output logic       code_valid,
    output logic       err_parity,
    output logic       err_frame
);
    localparam int TW = $clog2(TIMEOUT_TICKS + 1);
    localparam logic [TW-1:0]    IDLE_LAST = TW'(TIMEOUT_TICKS - 1);
    localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(FRAME_BITS - 1);

    frame_st_t     fr_d, fr_q;
    logic [TW-1:0] idle_d, idle_q;
    logic          first_bit;

    function automatic frame_st_t take_bit(input frame_st_t s, input logic b);
        frame_st_t r;
        r    = s;
        r.sh = {b, s.sh[FRAME_BITS-1:1]};
        if (s.cnt == CNT_LAST) begin
            r.cnt = '0;
            if (r.sh[0] || !r.sh[FRAME_BITS-1]) r.ferr = 1'b1;
            if (!(^r.sh[9:1]))                  r.perr = 1'b1;
            if (!r.ferr && !r.perr) begin
                r.code = r.sh[8:1];
                r.vld  = 1'b1;
            end
        end else begin
            r.cnt = s.cnt + 1'b1;
        end
        return r;
    endfunction

    always_comb begin
        fr_d      = fr_q;
        fr_d.vld  = 1'b0;
        fr_d.perr = 1'b0;
        fr_d.ferr = 1'b0;
        idle_d    = idle_q;
        flush     = 1'b0;
        first_bit = (nbits == 2'd2) ? win_bits[1] : win_bits[0];
        if (tick) begin
            if (fall) begin
                idle_d = '0;
            end else if (idle_q == IDLE_LAST) begin
                idle_d   = '0;
                flush    = 1'b1;
                fr_d.cnt = '0;
            end else begin
                idle_d = idle_q + 1'b1;
            end
        end
        if (win_end && !flush) begin
            if (nbits != 2'd0) fr_d = take_bit(fr_d, first_bit);
            if (nbits == 2'd2) fr_d = take_bit(fr_d, win_bits[0]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fr_q   <= '0;
            idle_q <= '0;
        end else begin
            fr_q   <= fr_d;
            idle_q <= idle_d;
        end
    end

    assign code       = fr_q.code;
    assign code_valid = fr_q.vld;
    assign err_parity = fr_q.perr;
    assign err_frame  = fr_q.ferr;

    // R5: bit count stays within one frame
    p_cnt_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fr_q.cnt <= CNT_LAST);

    // R5: code changes only with a valid strobe
    p_code_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fr_q.code) |-> fr_q.vld);

    // R8: a flush leaves no partial frame
    p_timeout_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> fr_q.cnt == '0);

    // R10: valid never with an error
    p_valid_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fr_q.vld |-> !(fr_q.perr || fr_q.ferr));

    // R10: strobes last one cycle
    p_strobe_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_q.vld || fr_q.perr || fr_q.ferr) |=> !(fr_q.vld || fr_q.perr || fr_q.ferr));
endmodule

// File: rtl/ps2s_rx.sv
module ps2s_rx #(
    parameter int SYNC_STAGES   = 2,
    parameter int TIMEOUT_TICKS = 80
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sample_tick,
    input  logic       win_end,
    input  logic       ps2_clk,
    input  logic       ps2_dat,
    output logic [7:0] code,
    output logic       code_valid,
    output logic       err_parity,
    output logic       err_frame
);
    logic       clk_s, dat_s;
    logic       fall, flush;
    logic [1:0] nbits, win_bits;

    ps2s_sync #(.STAGES(SYNC_STAGES)) u_sync_clk (
        .clk(clk), .rst_n(rst_n), .d(ps2_clk), .q(clk_s));
    ps2s_sync #(.STAGES(SYNC_STAGES)) u_sync_dat (
        .clk(clk), .rst_n(rst_n), .d(ps2_dat), .q(dat_s));

    ps2s_edge u_edge (
        .clk(clk), .rst_n(rst_n), .tick(sample_tick), .win_end(win_end),
        .flush(flush), .clk_lvl(clk_s), .dat_lvl(dat_s),
        .fall(fall), .nbits(nbits), .win_bits(win_bits));

    ps2s_frame #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_frame (
        .clk(clk), .rst_n(rst_n), .tick(sample_tick), .win_end(win_end),
        .fall(fall), .nbits(nbits), .win_bits(win_bits), .flush(flush),
        .code(code), .code_valid(code_valid),
        .err_parity(err_parity), .err_frame(err_frame));

    // R3: window close only happens on a tick
    p_win_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        win_end |-> sample_tick);
endmodule

// File: tb/sim_ps2s_rx.sv
module sim_ps2s_rx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sample_tick = 1'b0;
    logic       win_end = 1'b0;
    logic       ps2_clk = 1'b1;
    logic       ps2_dat = 1'b1;
    logic [7:0] code;
    logic       code_valid, err_parity, err_frame;

    int n_cmp = 0;
    int n_bad = 0;
    int win_len = 3;
    int tcnt = 0;
    int phase = 0;
    bit done = 1'b0;

    typedef struct {
        int         kind;   // 0 good, 1 parity error, 2 framing error
        logic [7:0] code;
        string      tag;
    } exp_t;
    exp_t expq[$];

    always #4 clk = ~clk;   // 125 MHz

    ps2s_rx #(.SYNC_STAGES(2), .TIMEOUT_TICKS(20)) u0 (
        .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .win_end(win_end),
        .ps2_clk(ps2_clk), .ps2_dat(ps2_dat), .code(code), .code_valid(code_valid),
        .err_parity(err_parity), .err_frame(err_frame));

    // tick every fourth clock, window close every win_len ticks
    initial begin
        forever begin
            @(negedge clk);
            phase = (phase + 1) % 4;
            sample_tick = rst_n && (phase == 3);
            win_end = sample_tick && ((tcnt % win_len) == win_len - 1);
            if (sample_tick) tcnt++;
        end
    end

    task automatic wait_ticks(input int n);
        repeat (4 * n) @(negedge clk);
    endtask

    task automatic put_bit(input logic b, input int h);
        ps2_dat = b;
        wait_ticks(h);
        ps2_clk = 1'b0;
        wait_ticks(h);
        ps2_clk = 1'b1;
    endtask

    task automatic send_frame(input logic [7:0] d, input int h, input bit bad_par,
                              input bit bad_start, input bit bad_stop, input string tag);
        logic [10:0] f;
        exp_t e;
        f = {~bad_stop, (~^d) ^ bad_par, d, bad_start};
        e.kind = (bad_start || bad_stop) ? 2 : (bad_par ? 1 : 0);
        e.code = d;
        e.tag  = tag;
        expq.push_back(e);
        for (int i = 0; i < 11; i++) put_bit(f[i], h);
        ps2_dat = 1'b1;
        wait_ticks(4 * h + 2);
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && (code_valid || err_parity || err_frame)) begin
                int kind;
                kind = code_valid ? 0 : (err_parity ? 1 : 2);
                n_cmp++;
                if (expq.size() == 0) begin
                    n_bad++;
                    $display("FAIL R10: unexpected strobe kind=%0d code=%02h, expected none", kind, code);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    if (kind != e.kind || (kind == 0 && code != e.code) ||
                        (code_valid + err_parity + err_frame) != 1) begin
                        n_bad++;
                        $display("FAIL %s: kind=%0d code=%02h, expected kind=%0d code=%02h",
                                 e.tag, kind, code, e.kind, e.code);
                    end
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        // R1: reset state
        n_cmp++;
        if (code !== 8'h00 || code_valid !== 1'b0 || err_parity !== 1'b0 || err_frame !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: code=%02h v=%b p=%b f=%b, expected 00 0 0 0",
                     code, code_valid, err_parity, err_frame);
        end
        rst_n = 1'b1;
        wait_ticks(6);
        n_cmp++;
        if (code !== 8'h00 || code_valid !== 1'b0 || err_parity !== 1'b0 || err_frame !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: after release code=%02h v=%b p=%b f=%b, expected 00 0 0 0",
                     code, code_valid, err_parity, err_frame);
        end

        // R3: two bits per window, fast clock
        win_len = 3;
        send_frame(8'h1C, 1, 0, 0, 0, "R3");
        send_frame(8'hA5, 1, 0, 0, 0, "R3");
        // R4/R5: one bit per window, varied patterns
        win_len = 5;
        send_frame(8'h00, 2, 0, 0, 0, "R5");
        send_frame(8'hFF, 2, 0, 0, 0, "R4");
        win_len = 7;
        send_frame(8'hF0, 3, 0, 0, 0, "R5");
        send_frame(8'h81, 3, 0, 0, 0, "R4");
        // R6, R7, R9
        win_len = 3;
        send_frame(8'h3C, 1, 1, 0, 0, "R6");
        send_frame(8'h55, 2, 0, 1, 0, "R7");
        send_frame(8'h77, 2, 0, 0, 1, "R7");
        send_frame(8'h12, 1, 0, 0, 0, "R9");
        // R2: glitch between ticks
        @(posedge clk iff sample_tick);
        @(negedge clk);
        ps2_clk = 1'b0;
        @(negedge clk);
        ps2_clk = 1'b1;
        wait_ticks(3);
        send_frame(8'h6B, 2, 0, 0, 0, "R2");
        // R8: partial frame abandoned after quiet period
        for (int i = 0; i < 5; i++) put_bit(1'b0, 2);
        ps2_dat = 1'b1;
        wait_ticks(30);
        send_frame(8'hC3, 2, 0, 0, 0, "R8");

        wait_ticks(20);
        // R10: every expected strobe observed, none left over
        n_cmp++;
        if (expq.size() != 0) begin
            n_bad++;
            $display("FAIL R10: %0d expected strobes missing, expected 0", expq.size());
        end
        finish_run();
    end
endmodule